// File: doc/BRIEF.md
# Frame-Memory Rectangle Transfer Engine

This block copies a rectangle of 16-bit pixels between a 32-bit word stream and a frame memory that is 1024 pixels wide and 512 rows tall. It works in both directions. A three-word start command selects the direction and supplies a position word and a size word. After that, each 32-bit word holds two pixels. On a write, words arrive on the input stream and become memory writes. On a read, the consumer pulls words with a pop strobe.

The engine walks the rectangle one row at a time. Column and row counters persist between words, so data can arrive in any chunking and the transfer carries on from the exact pixel where it paused, including partway through a row. The frame-memory side has two pixel lanes, so one word is handled per cycle. Memory reads are synchronous, with one cycle of latency. A status output shows that a read is in progress, and a one-cycle pulse marks the end of a write so that the frame can be treated as modified. On writes, an input can force the top bit of every stored pixel to 1.

Top module: `vram_rect_xfer`

## Requirements
- R1: While idle, a word whose bits 31..29 are 3'b101 starts a write and a word whose bits 31..29 are 3'b110 starts a read. The next two accepted words are the position word and the size word. Any other word seen while idle and outside a command causes no memory access and no status change.
- R2: The start column x comes from position bits 9..0 and the start row y comes from position bits 24..16. All other position bits are ignored.
- R3: Width is ((size[9:0] − 1) mod 1024) + 1 and height is ((size[24:16] − 1) mod 512) + 1. A zero field therefore means 1024 columns or 512 rows.
- R4: Pixel i of a transfer sits at column (x + i mod width) mod 1024 and row (y + i div width) mod 512. Its memory address is row*1024 + column, with the row in address bits 18..10. Word bits 15..0 carry the even pixel on lane 0 and bits 31..16 carry the odd pixel on lane 1.
- R5: Rows wrap from 511 to 0.
- R6: On a write with mask_force high, bit 15 of each stored pixel is 1, whatever the data held.
- R7: img_ready goes high in the cycle after the size word of a read is accepted. It goes low in the cycle after the pop that reads the last pixel.
- R8: wr_done pulses high for exactly one cycle, in the cycle after the word that holds the last pixel of a write is accepted.
- R9: A word may span the end of one row and the start of the next. Transfers resume correctly after any number of idle cycles between words.
- R10: During a write, every input word is pixel data, even when its top bits look like a start opcode.
- R11: A start opcode that arrives during a read ends that read at once. A pop in the same cycle is still served from the old read. A pop while no read is active returns nothing.
- R12: rd_valid and rd_data appear one cycle after an accepted pop. When the transfer ends on an even pixel, bits 31..16 of rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command or data word present |
| in_data | input | 32 | Command or data word |
| mask_force | input | 1 | Force pixel bit 15 on writes |
| rd_pop | input | 1 | Request the next read word |
| rd_valid | output | 1 | rd_data holds a read word |
| rd_data | output | 32 | Two pixels read, low half first |
| img_ready | output | 1 | Read transfer in progress |
| wr_done | output | 1 | Write transfer completed (pulse) |
| mem_we0 | output | 1 | Lane 0 write enable |
| mem_we1 | output | 1 | Lane 1 write enable |
| mem_re0 | output | 1 | Lane 0 read enable |
| mem_re1 | output | 1 | Lane 1 read enable |
| mem_addr0 | output | 19 | Lane 0 pixel address |
| mem_addr1 | output | 19 | Lane 1 pixel address |
| mem_wdata0 | output | 16 | Lane 0 write pixel |
| mem_wdata1 | output | 16 | Lane 1 write pixel |
| mem_rdata0 | input | 16 | Lane 0 read pixel, one cycle after read enable |
| mem_rdata1 | input | 16 | Lane 1 read pixel, one cycle after read enable |

## Verification
A pop of a running read and a new start opcode can land on the same clock edge. In that cycle the counters both advance for the old read and reinitialise for the new command. The bench drives rd_pop and a write opcode in one cycle partway through a read. It then expects the returned word to hold the old read's next two pixels, img_ready to drop, and the following position, size and data words to write the new rectangle to the addresses computed by the bench. A later pop with no read active must return no valid word.

// File: rtl/vram_rect_xfer.sv
module vram_rect_xfer #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  input  logic              mask_force,
  input  logic              rd_pop,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              img_ready,
  output logic              wr_done,
  output logic              mem_we0,
  output logic              mem_we1,
  output logic              mem_re0,
  output logic              mem_re1,
  output logic [XW+YW-1:0]  mem_addr0,
  output logic [XW+YW-1:0]  mem_addr1,
  output logic [15:0]       mem_wdata0,
  output logic [15:0]       mem_wdata1,
  input  logic [15:0]       mem_rdata0,
  input  logic [15:0]       mem_rdata1
);
  localparam int AW = XW + YW;

  logic          active, is_read, rd_hi;
  logic [1:0]    hdr;
  logic [XW-1:0] x0, col;
  logic [XW:0]   wid;
  logic [YW-1:0] row;
  logic [YW:0]   left;

  logic          wr_fire, rd_fire, lane1, is_start;
  logic [XW:0]   col_a, col_b;
  logic          eol_a, eol_b;
  logic [XW-1:0] c1, c2;
  logic [YW-1:0] r1, r2;
  logic [YW:0]   l1, l2;
  logic [15:0]   msb;

  assign wr_fire = in_valid && active && !is_read;
  assign rd_fire = rd_pop && active && is_read;

  assign col_a = {1'b0, col} + 1'b1;
  assign eol_a = (col_a == wid);
  assign c1    = eol_a ? '0 : col_a[XW-1:0];
  assign r1    = row + YW'(eol_a);
  assign l1    = left - (YW+1)'(eol_a);

  assign col_b = {1'b0, c1} + 1'b1;
  assign eol_b = (col_b == wid);
  assign c2    = eol_b ? '0 : col_b[XW-1:0];
  assign r2    = r1 + YW'(eol_b);
  assign l2    = l1 - (YW+1)'(eol_b);

  assign lane1 = (l1 != '0);

  assign mem_addr0  = AW'({row, x0 + col});
  assign mem_addr1  = AW'({r1, x0 + c1});
  assign msb        = {mask_force, 15'b0};
  assign mem_wdata0 = in_data[15:0] | msb;
  assign mem_wdata1 = in_data[31:16] | msb;
  assign mem_we0    = wr_fire;
  assign mem_we1    = wr_fire && lane1;
  assign mem_re0    = rd_fire;
  assign mem_re1    = rd_fire && lane1;

  assign rd_data   = {rd_hi ? mem_rdata1 : 16'h0, mem_rdata0};
  assign img_ready = active && is_read;
  assign is_start  = (in_data[31:29] == 3'b101) || (in_data[31:29] == 3'b110);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_read  <= 1'b0;
      hdr      <= 2'd0;
      x0       <= '0;
      col      <= '0;
      wid      <= '0;
      row      <= '0;
      left     <= '0;
      rd_valid <= 1'b0;
      rd_hi    <= 1'b0;
      wr_done  <= 1'b0;
    end else begin
      wr_done  <= 1'b0;
      rd_valid <= rd_fire;
      rd_hi    <= rd_fire && lane1;
      if (wr_fire || rd_fire) begin
        col  <= lane1 ? c2 : c1;
        row  <= lane1 ? r2 : r1;
        left <= lane1 ? l2 : l1;
        if (!lane1 || l2 == '0) begin
          active  <= 1'b0;
          wr_done <= !is_read;
        end
      end
      if (in_valid && !wr_fire) begin
        case (hdr)
          2'd0: if (is_start) begin
            hdr     <= 2'd1;
            active  <= 1'b0;
            is_read <= in_data[30];
          end
          2'd1: begin
            x0  <= in_data[XW-1:0];
            row <= in_data[16 +: YW];
            hdr <= 2'd2;
          end
          default: begin
            wid    <= {1'b0, in_data[XW-1:0] - 1'b1} + 1'b1;
            left   <= {1'b0, in_data[16 +: YW] - 1'b1} + 1'b1;
            col    <= '0;
            active <= 1'b1;
            hdr    <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/vram_rect_xfer_chk.sv
module vram_rect_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        mask_force,
  input logic        rd_pop,
  input logic        rd_valid,
  input logic        img_ready,
  input logic        wr_done,
  input logic        mem_we0,
  input logic        mem_we1,
  input logic        mem_re0,
  input logic        mem_re1,
  input logic [15:0] mem_wdata0,
  input logic [15:0] mem_wdata1
);
  p_lane_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we1 |-> mem_we0) and (mem_re1 |-> mem_re0));

  p_write_needs_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we0 |-> in_valid);

  p_read_needs_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re0 |-> rd_pop);

  p_mask_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we0 && mask_force) |-> (mem_wdata0[15] && (!mem_we1 || mem_wdata1[15])));

  p_no_write_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> !(mem_we0 || mem_we1));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_data_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(mem_re0) && $past(img_ready)));
endmodule

bind vram_rect_xfer vram_rect_xfer_chk u_chk (.*);

// File: tb/sim_vram_rect_xfer.sv
module sim_vram_rect_xfer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, mask_force = 0, rd_pop = 0;
  logic [31:0] in_data = 0;
  logic        rd_valid, img_ready, wr_done;
  logic [31:0] rd_data;
  logic        mem_we0, mem_we1, mem_re0, mem_re1;
  logic [18:0] mem_addr0, mem_addr1;
  logic [15:0] mem_wdata0, mem_wdata1;
  logic [15:0] mem_rdata0, mem_rdata1;

  int nchk = 0, nfail = 0, wcnt = 0;
  logic [15:0] dmem [logic [18:0]];
  logic [15:0] expm [logic [18:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_rect_xfer u0 (.*);

  function automatic logic [15:0] init_pix(logic [18:0] a);
    return 16'(a * 7 + 3) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] mem_rd(logic [18:0] a);
    return dmem.exists(a) ? dmem[a] : init_pix(a);
  endfunction

  function automatic logic [15:0] exp_rd(logic [18:0] a);
    return expm.exists(a) ? expm[a] : init_pix(a);
  endfunction

  function automatic logic [18:0] paddr(int x0, int y0, int w, int i);
    int x = (x0 + i % w) % 1024;
    int y = (y0 + i / w) % 512;
    return 19'(y * 1024 + x);
  endfunction

  always @(posedge clk) begin
    if (mem_we0) begin dmem[mem_addr0] = mem_wdata0; wcnt++; end
    if (mem_we1) begin dmem[mem_addr1] = mem_wdata1; wcnt++; end
    mem_rdata0 <= mem_re0 ? mem_rd(mem_addr0) : 16'hxxxx;
    mem_rdata1 <= mem_re1 ? mem_rd(mem_addr1) : 16'hxxxx;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] d);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic gap(input int g);
    repeat (g) @(negedge clk);
  endtask

  task automatic start(input bit rd, input int x0, input int y0, input int wf, input int hf);
    logic [31:0] op = {rd ? 3'b110 : 3'b101, 29'($urandom)};
    put(op);
    put(32'((y0 & 511) << 16) | 32'(x0 & 1023) | (32'($urandom % 64) << 10));
    put(32'((hf & 511) << 16) | 32'(wf & 1023) | (32'($urandom % 64) << 10));
  endtask

  task automatic do_write(input int x0, input int y0, input int wf, input int hf,
                          input bit msk, input int gmax, input bit oplike);
    int w = ((wf - 1) & 1023) + 1;
    int h = ((hf - 1) & 511) + 1;
    int np = w * h;
    int nw = (np + 1) / 2;
    int w0;
    int bad = 0;
    logic [18:0] bad_a = 0;
    mask_force = msk;
    start(1'b0, x0, y0, wf, hf);
    w0 = wcnt;
    for (int k = 0; k < nw; k++) begin
      logic [31:0] d = $urandom;
      if (oplike) d = (k % 2 == 1) ? 32'hC000_1234 : {8'hA5, 8'h00, 16'(d)};
      expm[paddr(x0, y0, w, 2*k)] = d[15:0] | {msk, 15'b0};
      if (2*k + 1 < np) expm[paddr(x0, y0, w, 2*k+1)] = d[31:16] | {msk, 15'b0};
      put(d);
      if (k < nw - 1 && gmax > 0) gap($urandom % (gmax + 1));
    end
    chk(wr_done === 1'b1, "R8 wr_done after last word", 32'(wr_done), 1);
    gap(1);
    chk(wr_done === 1'b0, "R8 wr_done single cycle", 32'(wr_done), 0);
    chk(wcnt - w0 == np, "R3 pixel write count", 32'(wcnt - w0), 32'(np));
    for (int i = 0; i < np; i++) begin
      logic [18:0] a = paddr(x0, y0, w, i);
      if (!dmem.exists(a) || dmem[a] !== expm[a]) begin
        if (bad == 0) bad_a = a;
        bad++;
      end
    end
    chk(bad == 0, oplike ? "R10 data words written" : "R4/R9 pixel placement",
        dmem.exists(bad_a) ? 32'(dmem[bad_a]) : 32'hDEAD, 32'(expm[bad_a]));
    mask_force = 0;
  endtask

  task automatic do_read(input int x0, input int y0, input int wf, input int hf, input int gmax);
    int w = ((wf - 1) & 1023) + 1;
    int h = ((hf - 1) & 511) + 1;
    int np = w * h;
    int nw = (np + 1) / 2;
    start(1'b1, x0, y0, wf, hf);
    chk(img_ready === 1'b1, "R7 img_ready set", 32'(img_ready), 1);
    for (int k = 0; k < nw; k++) begin
      logic [31:0] e;
      e[15:0]  = exp_rd(paddr(x0, y0, w, 2*k));
      e[31:16] = (2*k + 1 < np) ? exp_rd(paddr(x0, y0, w, 2*k+1)) : 16'h0;
      rd_pop = 1;
      @(negedge clk);
      rd_pop = 0;
      chk(rd_valid === 1'b1 && rd_data === e, "R12/R4 read word", rd_data, e);
      if (gmax > 0) gap($urandom % (gmax + 1));
    end
    chk(img_ready === 1'b0, "R7 img_ready cleared", 32'(img_ready), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    gap(3);
    rst_n = 1;
    @(negedge clk);
    chk(img_ready === 0 && rd_valid === 0 && wr_done === 0 && mem_we0 === 0,
        "R1 reset state", {img_ready, rd_valid, wr_done, mem_we0}, 0);

    // R1: stray words while idle are ignored
    begin
      int w0 = wcnt;
      put(32'hE100_0000); put(32'h0200_0000); put(32'h7FFF_FFFF); put(32'hE3FF_FFFF);
      chk(wcnt == w0 && img_ready === 0, "R1 idle words ignored", 32'(wcnt - w0), 0);
    end

    // R3: zero width field -> 1024 columns, column wrap within the row
    do_write(5, 7, 0, 1, 1'b0, 0, 1'b0);
    // R3/R5: zero height field -> 512 rows, row wrap from 511
    do_write(1023, 300, 1, 0, 1'b0, 0, 1'b0);
    // R10: data that looks like start opcodes
    do_write(100, 200, 2, 2, 1'b0, 1, 1'b1);
    // R6: mask bit forced
    do_write(40, 50, 5, 3, 1'b1, 2, 1'b0);
    // R5/R9: odd width across last row wrap, read back
    do_write(1020, 510, 7, 4, 1'b0, 3, 1'b0);
    do_read(1020, 510, 7, 4, 2);
    // R12: odd pixel count leaves upper half zero
    do_read(40, 50, 3, 1, 0);

    // R11: pop and new start opcode in the same cycle
    begin
      logic [31:0] e;
      do_write(10, 20, 4, 2, 1'b0, 0, 1'b0);
      start(1'b1, 10, 20, 4, 2);
      rd_pop = 1; @(negedge clk); rd_pop = 0;
      e = {exp_rd(paddr(10, 20, 4, 1)), exp_rd(paddr(10, 20, 4, 0))};
      chk(rd_valid === 1 && rd_data === e, "R11 first word before abort", rd_data, e);
      e = {exp_rd(paddr(10, 20, 4, 3)), exp_rd(paddr(10, 20, 4, 2))};
      rd_pop = 1; in_valid = 1; in_data = 32'hA000_0000;
      @(negedge clk);
      rd_pop = 0; in_valid = 0;
      chk(rd_valid === 1 && rd_data === e, "R11 pop served in abort cycle", rd_data, e);
      chk(img_ready === 0, "R11 read aborted", 32'(img_ready), 0);
      put(32'h0003_02BC);
      put(32'h0001_0002);
      put(32'hBEEF_CAFE);
      expm[paddr(700, 3, 2, 0)] = 16'hCAFE;
      expm[paddr(700, 3, 2, 1)] = 16'hBEEF;
      chk(wr_done === 1, "R11 new write completes", 32'(wr_done), 1);
      chk(dmem[paddr(700, 3, 2, 0)] === 16'hCAFE && dmem[paddr(700, 3, 2, 1)] === 16'hBEEF,
          "R11 R2 new write placement", {dmem[paddr(700, 3, 2, 1)], dmem[paddr(700, 3, 2, 0)]},
          32'hBEEF_CAFE);
      rd_pop = 1; @(negedge clk); rd_pop = 0;
      chk(rd_valid === 0, "R11 pop while idle", 32'(rd_valid), 0);
    end

    // Random mix
    for (int t = 0; t < 40; t++) begin
      int x = ($urandom % 4 == 0) ? 1023 - int'($urandom % 8) : int'($urandom % 1024);
      int y = ($urandom % 4 == 0) ? 511 - int'($urandom % 4) : int'($urandom % 512);
      int wf = 1 + int'($urandom % 24);
      int hf = 1 + int'($urandom % 6);
      do_write(x, y, wf, hf, 1'($urandom), 3, 1'b0);
      if ($urandom % 2 == 1) gap($urandom % 4);
      do_read(x, y, wf, hf, 2);
    end

    gap(2);
    finish_run();
  end
endmodule